// File: doc/BRIEF.md
# Sequential Single-Multiplier FIR Filter

This block computes a finite impulse response filter of configurable length with one shared multiplier. Each accepted input sample is written into a circular history store. The block then walks that store and a separate circular coefficient store in lockstep, one product per clock, and sums the products in a wide accumulator. Because the two stores are distinct, each step reads one sample and one coefficient in the same cycle.

Only the last multiply-accumulate step adds the rounding offset. The sum keeps its full width until that point. The result is then cut down to a 16-bit signed value with saturation and is presented for one cycle. The history write pointer then steps back one slot, so the next sample lands on the oldest entry.

Samples and coefficients are signed Q1.15. Coefficients are loaded through a simple address/data/write-enable port while the filter is idle.

Top module: `fir_mac_seq`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, and every history and coefficient entry is zero, so the first output after reset depends only on the first sample.
- R2: A sample accepted at clock edge e (`in_valid` and `in_ready` both high) produces `out_valid` high for exactly one cycle, starting right after edge e+TAPS. The next sample can be accepted at edge e+TAPS+2, so one sample takes TAPS+2 cycles.
- R3: The output is y(n) = sum over k = 0..TAPS-1 of c[k]·x(n-k), where c[k] is the coefficient written at `cf_addr` = k and x(n-k) is the sample accepted k samples earlier.
- R4: The exact sum, in units of 2^-30, is rounded to nearest at bit 15 with ties toward plus infinity: out = floor((sum + 2^14) / 2^15). For example, with c[0] = 0x4000, an input of 1 gives 1, an input of -1 gives 0, an input of 3 gives 2, and an input of -3 gives -1.
- R5: A rounded result above 32767 is output as 32767 (0x7FFF), and one below -32768 is output as -32768 (0x8000).
- R6: Partial sums are never clipped. A sum whose running value leaves the 16-bit output range but whose final value is in range comes out exact.
- R7: `in_ready` is 0 from the accepting edge until `out_valid` has been high. An `in_valid` pulse in that window has no effect on any output.
- R8: A coefficient write made while `in_ready` is 0 is ignored. A write made while `in_ready` is 1 takes effect from the next accepted sample.
- R9: The history is circular. Once more than TAPS samples have been accepted, each new sample replaces the oldest one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block is idle and will take a sample |
| in_data | input | DW | Signed Q1.15 input sample |
| out_valid | output | 1 | One-cycle strobe marking a result |
| out_data | output | DW | Rounded, saturated Q1.15 result |
| cf_we | input | 1 | Coefficient write enable |
| cf_addr | input | AW | Coefficient tap index, 0 = newest sample |
| cf_data | input | DW | Signed Q1.15 coefficient |

## Verification
The hardest cases to reach from the ports are a sample offer and a coefficient write that arrive while a pass is running. Only a bench that deliberately intrudes mid-pass creates them. The stimulus accepts a sample and, in the very next cycle, raises `in_valid` with a marker value and writes a marker coefficient to tap 0. The following outputs must match a model that never saw either marker. Intermediate-overflow and tie-rounding cases are reached by loading coefficient sets picked so that partial sums leave the output range or land exactly on a half step.

// File: rtl/fir_mac_seq.sv
module fir_mac_seq #(
  parameter int TAPS  = 8,
  parameter int DW    = 16,
  parameter int GUARD = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic signed [DW-1:0]         in_data,
  output logic                         out_valid,
  output logic signed [DW-1:0]         out_data,
  input  logic                         cf_we,
  input  logic [(TAPS>1?$clog2(TAPS):1)-1:0] cf_addr,
  input  logic signed [DW-1:0]         cf_data
);
  localparam int AW   = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int PW   = 2 * DW;
  localparam int ACCW = PW + GUARD;
  localparam int FRAC = DW - 1;
  localparam int TOP  = FRAC + DW - 1;
  localparam int LW   = $clog2(TAPS + 1) + 1;
  localparam logic signed [ACCW-1:0] HALF =
    {{(ACCW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic [AW-1:0] LAST = AW'(TAPS - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_t;

  st_t                    st;
  logic signed [DW-1:0]   hist [TAPS];
  logic signed [DW-1:0]   coef [TAPS];
  logic [AW-1:0]          wp, rp, cp, cnt;
  logic signed [ACCW-1:0] acc;
  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] prod_x;
  logic                   last_step;
  logic [ACCW-TOP-1:0]    hi_bits;

  function automatic logic [AW-1:0] step_up(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] step_down(input logic [AW-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  assign in_ready  = (st == S_IDLE);
  assign out_valid = (st == S_DONE);
  assign prod      = hist[rp] * coef[cp];
  assign prod_x    = ACCW'(prod);
  assign last_step = (cnt == LAST);
  assign hi_bits   = acc[ACCW-1:TOP];

  always_comb begin
    if (!acc[ACCW-1] && (|hi_bits))
      out_data = {1'b0, {(DW-1){1'b1}}};
    else if (acc[ACCW-1] && !(&hi_bits))
      out_data = {1'b1, {(DW-1){1'b0}}};
    else
      out_data = acc[TOP:FRAC];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      wp  <= '0;
      rp  <= '0;
      cp  <= '0;
      cnt <= '0;
      acc <= '0;
      for (int i = 0; i < TAPS; i++) begin
        hist[i] <= '0;
        coef[i] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: begin
          if (cf_we && (int'(cf_addr) < TAPS)) coef[cf_addr] <= cf_data;
          if (in_valid) begin
            hist[wp] <= in_data;
            acc      <= '0;
            rp       <= wp;
            cp       <= '0;
            cnt      <= '0;
            st       <= S_RUN;
          end
        end
        S_RUN: begin
          acc <= acc + prod_x + (last_step ? HALF : '0);
          rp  <= step_up(rp);
          cp  <= step_up(cp);
          cnt <= cnt + 1'b1;
          if (last_step) st <= S_DONE;
        end
        S_DONE: begin
          wp <= step_down(wp);
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [LW-1:0] since_acc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_acc <= '0;
    else if (in_valid && in_ready) since_acc <= '0;
    else if (since_acc != {LW{1'b1}}) since_acc <= since_acc + 1'b1;
  end

  // R2
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R2
  result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (since_acc == LW'(TAPS)));

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R7
  ready_after_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> in_ready);

  // R8
  coef_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_we && !in_ready) |=> (coef[$past(cf_addr)] == $past(coef[cf_addr])));
endmodule

// File: tb/sim_fir_mac_seq.sv
module sim_fir_mac_seq;
  localparam int TAPS = 8;
  localparam int DW   = 16;
  localparam int AW   = $clog2(TAPS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic signed [DW-1:0] out_data;
  logic cf_we = 1'b0;
  logic [AW-1:0] cf_addr = '0;
  logic signed [DW-1:0] cf_data = '0;

  always #2.5 clk = ~clk;

  fir_mac_seq #(.TAPS(TAPS), .DW(DW), .GUARD(8)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .cf_we(cf_we), .cf_addr(cf_addr), .cf_data(cf_data));

  typedef struct { longint exp; string tag; longint acc_cyc; } item_t;
  item_t q[$];

  int total = 0, failed = 0;
  longint cyc = 0;
  bit finished = 0;
  longint mhist [TAPS];
  longint mcoef [TAPS];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint model_push(input longint x);
    longint s, r;
    for (int k = TAPS-1; k > 0; k--) mhist[k] = mhist[k-1];
    mhist[0] = x;
    s = 0;
    for (int k = 0; k < TAPS; k++) s += mcoef[k] * mhist[k];
    r = (s + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic load_coef(input int k, input longint v);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    cf_we = 1'b1; cf_addr = AW'(k); cf_data = DW'(v);
    @(negedge clk);
    cf_we = 1'b0;
    mcoef[k] = v;
  endtask

  task automatic send(input longint x, input string tag, input bit intrude);
    item_t it;
    it.exp = model_push(x);
    it.tag = tag;
    @(negedge clk);
    in_valid = 1'b1; in_data = DW'(x);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    it.acc_cyc = cyc;
    q.push_back(it);
    in_valid = 1'b0;
    if (intrude) begin
      chk(in_ready == 1'b0, "R7", in_ready, 0);
      in_valid = 1'b1; in_data = 16'sh5A5A;
      cf_we = 1'b1; cf_addr = '0; cf_data = 16'sh7000;
      @(negedge clk);
      in_valid = 1'b0; cf_we = 1'b0;
    end
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && !finished) begin
      if (q.size() == 0) chk(1'b0, "R2", out_data, 0);
      else begin
        item_t it;
        it = q.pop_front();
        chk(out_data == it.exp, it.tag, out_data, it.exp);
        chk(cyc - it.acc_cyc == TAPS, "R2", cyc - it.acc_cyc, TAPS);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    logic [15:0] lf;
    for (int k = 0; k < TAPS; k++) begin mhist[k] = 0; mcoef[k] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", in_ready, 1);

    // R1: zero coefficients after reset give zero
    send(12345, "R1", 0);
    drain();

    // R3: impulse response through graded taps
    for (int k = 0; k < TAPS; k++) load_coef(k, (k + 1) * 1024);
    send(16384, "R3", 0);
    for (int k = 0; k < TAPS + 1; k++) send(0, "R3", 0);
    drain();

    // R9: long pseudo-random stream wraps the circular history
    lf = 16'hACE1;
    for (int n = 0; n < 3 * TAPS; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      send(longint'($signed(lf)), "R9", 0);
    end
    drain();

    // R4: ties round upward
    for (int k = 0; k < TAPS; k++) load_coef(k, (k == 0) ? 16384 : 0);
    send(1, "R4", 0);
    send(-1, "R4", 0);
    send(3, "R4", 0);
    send(-3, "R4", 0);
    drain();

    // R5: saturation both ways
    for (int k = 0; k < TAPS; k++) load_coef(k, 32767);
    for (int n = 0; n < TAPS; n++) send(32767, "R5", 0);
    for (int n = 0; n < TAPS; n++) send(-32768, "R5", 0);
    drain();

    // R6: partial sums exceed output range, final is zero
    for (int k = 0; k < TAPS; k++) load_coef(k, (k < 2) ? 32767 : (k < 4) ? -32767 : 0);
    for (int n = 0; n < TAPS; n++) send(32767, "R6", 0);
    drain();

    // R7 and R8: mid-pass sample and coefficient write are ignored
    send(-20000, "R7", 1);
    send(15000, "R8", 1);
    send(30000, "R8", 0);
    send(-1000, "R7", 0);
    drain();

    // R8: write while idle takes effect on next sample
    load_coef(0, -16384);
    send(8192, "R8", 0);
    drain();

    summary();
  end
endmodule